// File: doc/BRIEF.md
# Current-Regulated Hard-Chopping PWM Generator

This block produces the six gate drives of a three-phase half-bridge inverter that feeds a trapezoidal permanent-magnet motor with two phases conducting at a time. A symmetric triangle carrier sets a fixed switching frequency. With the default period count of 500 and a 20 MHz count rate, that frequency is 20 kHz. At the carrier peak, which is the middle of the conduction pulse, the block raises a one-clock conversion request and takes the 10-bit shunt current sample. Because the shunt current is zero or negative during the off-time, only a sample taken there is meaningful.

The block compares the sample with the current reference. It moves a shadow compare value by the error scaled with a power-of-two gain and clamps the result to the carrier range. The active compare takes the shadow value at the start of the next carrier cycle. A phase pair chosen by the commutation sector is then chopped: the high-side switch of the source phase and the low-side switch of the return phase carry the same pulse. The third phase stays open. Each leg has a programmable dead band, and an active-high fault input forces every gate low.

Top module: `chop_pwm_top`

## Requirements
- R1: The carrier counts 0,1,…,PERIOD,PERIOD-1,…,1 and repeats, so one cycle lasts 2·PERIOD clocks. The counter is 0 right after reset. `conv_req` is a one-clock pulse while the counter equals PERIOD, so it first rises PERIOD clocks after reset release and then every 2·PERIOD clocks.
- R2: Inputs are unsigned 10-bit values, with 0x000 meaning 0 A and 0x3FF meaning full scale (30 A). In the clock where `conv_req` is high, the shadow compare becomes old − (cur_ref − cur_meas)·2^K_SHIFT. The sum is formed at full width, so it cannot wrap.
- R3: The shadow compare is clamped to the range 0 … PERIOD.
- R4: The active compare loads the shadow value in the clock where the counter is 0. The conduction pulse is on while counter > compare, which gives 2·(PERIOD−c)−1 clocks per cycle for c < PERIOD and none for c = PERIOD. A smaller compare therefore means more current.
- R5: The sector code selects the pair as (source, return): 0=(A,B), 1=(A,C), 2=(B,C), 3=(B,A), 4=(C,A), 5=(C,B). `gate_hi[src]` and `gate_lo[ret]` both follow the pulse, and the other four gates stay low. Bit 0 is leg A, bit 1 is leg B, bit 2 is leg C.
- R6: Sector codes 6 and 7 hold all six gates low.
- R7: On each leg the two gates are never high together. A gate rises only after its partner has been low for at least `dead_cycles` clocks.
- R8: From the first clock edge that samples `fault` high, all gates are low for as long as it stays high. The pulses resume in the following cycles once it is released.
- R9: A synchronous reset clears the counter, sets both compares to PERIOD and drives all gates and `conv_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_ref | input | SMP_W | Current reference, unsigned |
| cur_meas | input | SMP_W | Sampled shunt current, taken while `conv_req` is high |
| sector | input | 3 | Commutation sector 0..5, other codes mean off |
| dead_cycles | input | DT_W | Dead band in clocks |
| fault | input | 1 | Active-high gate kill |
| conv_req | output | 1 | Conversion request at the carrier peak |
| gate_hi | output | 3 | High-side gates, bit per leg A/B/C |
| gate_lo | output | 3 | Low-side gates, bit per leg A/B/C |

## Verification
A wrong compare shows up directly as a wrong pulse width on the selected gates. A fault in the regulator arithmetic or the clamp therefore appears one carrier cycle after the peak that sampled the bad value, and the bench measures that width for every stimulus vector. A bad sector decode or a broken dead-band counter shows up within the same cycle as a stray gate or as a partner turn-on that comes too early. A mis-ordered carrier moves `conv_req` off its 2·PERIOD spacing from the very first peak after reset.

// File: rtl/chop_pkg.sv
// Shared types for the chopping PWM generator.
// Assumes legs are numbered 0=A, 1=B, 2=C.
package chop_pkg;

    typedef struct packed {
        logic       vld;
        logic [1:0] src;
        logic [1:0] ret;
    } leg_pair_t;

    // Map a commutation sector onto its source and return legs.
    function automatic leg_pair_t decode_sector(input logic [2:0] s);
        leg_pair_t p;
        p.vld = 1'b1;
        p.src = 2'd0;
        p.ret = 2'd1;
        case (s)
            3'd0: begin p.src = 2'd0; p.ret = 2'd1; end
            3'd1: begin p.src = 2'd0; p.ret = 2'd2; end
            3'd2: begin p.src = 2'd1; p.ret = 2'd2; end
            3'd3: begin p.src = 2'd1; p.ret = 2'd0; end
            3'd4: begin p.src = 2'd2; p.ret = 2'd0; end
            3'd5: begin p.src = 2'd2; p.ret = 2'd1; end
            default: p.vld = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/chop_carrier.sv
// Symmetric up/down carrier counter.
// Counts 0..PERIOD..1 and repeats. It flags the peak (middle of the
// conduction pulse) and the cycle start. Assumes PERIOD >= 2.
module chop_carrier #(
    parameter int PERIOD = 500,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             at_peak,
    output logic             at_start
);
    localparam logic [CNT_W-1:0] PER_C = CNT_W'(PERIOD);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic up_q;

    // Triangle counter with a direction flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (up_q) begin
            cnt <= cnt + ONE_C;
            if (cnt == PER_C - ONE_C) up_q <= 1'b0;
        end else begin
            cnt <= cnt - ONE_C;
            if (cnt == ONE_C) up_q <= 1'b1;
        end
    end

    // Event flags decoded from the count.
    assign at_peak  = (cnt == PER_C);
    assign at_start = (cnt == '0);

    assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= PER_C);
    assert_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
        at_peak |=> (cnt == PER_C - ONE_C));
endmodule

// File: rtl/chop_regulator.sv
// Incremental current regulator with clamp and double-buffered compare.
// At the peak it moves the shadow compare by the scaled error (ref - meas).
// A positive error lowers the compare, which widens the pulse. The sum is
// formed at full width, so it cannot wrap before the clamp. The active
// compare copies the shadow at each cycle start.
module chop_regulator #(
    parameter int PERIOD  = 500,
    parameter int CNT_W   = $clog2(PERIOD + 1),
    parameter int SMP_W   = 10,
    parameter int K_SHIFT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_peak,
    input  logic             at_start,
    input  logic [SMP_W-1:0] cur_ref,
    input  logic [SMP_W-1:0] cur_meas,
    output logic [CNT_W-1:0] cmp_act
);
    localparam int ERR_W = SMP_W + 1;
    localparam int SC_W  = (K_SHIFT > 0) ? ERR_W + K_SHIFT : ERR_W;
    localparam int SUM_W = ((SC_W > CNT_W + 1) ? SC_W : CNT_W + 1) + 1;
    localparam logic [CNT_W-1:0]        PER_C = CNT_W'(PERIOD);
    localparam logic signed [SUM_W-1:0] PER_S = SUM_W'(PERIOD);

    logic [CNT_W-1:0]        cmp_sh;
    logic signed [ERR_W-1:0] err;
    logic signed [SC_W-1:0]  err_ext;
    logic signed [SC_W-1:0]  scaled;
    logic signed [SUM_W-1:0] sum;
    logic [CNT_W-1:0]        cmp_next;

    // Signed error between the reference and the sample.
    assign err     = $signed({1'b0, cur_ref}) - $signed({1'b0, cur_meas});
    assign err_ext = SC_W'(err);

    // The gain is a power of two: the sign of K_SHIFT picks the direction.
    generate
        if (K_SHIFT >= 0) begin : g_left
            assign scaled = err_ext <<< K_SHIFT;
        end else begin : g_right
            assign scaled = err_ext >>> (-K_SHIFT);
        end
    endgenerate

    // Full-width update followed by the clamp to 0..PERIOD.
    always_comb begin
        sum = SUM_W'($signed({1'b0, cmp_sh})) - SUM_W'(scaled);
        if (sum < 0)          cmp_next = '0;
        else if (sum > PER_S) cmp_next = PER_C;
        else                  cmp_next = sum[CNT_W-1:0];
    end

    // Shadow update at the peak; active load at the cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_sh  <= PER_C;
            cmp_act <= PER_C;
        end else begin
            if (at_peak)  cmp_sh  <= cmp_next;
            if (at_start) cmp_act <= cmp_sh;
        end
    end

    assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_sh <= PER_C) && (cmp_act <= PER_C));
    assert_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(at_peak) |-> $stable(cmp_sh));
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(at_start) |-> $stable(cmp_act));
endmodule

// File: rtl/chop_steer.sv
// Pulse comparator and hard-chopping steering.
// The pulse is on while count > compare. Both switches of the selected
// pair follow it. Invalid sectors request nothing.
module chop_steer #(
    parameter int CNT_W = 9
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic [2:0]       sector,
    output logic [2:0]       hi_req,
    output logic [2:0]       lo_req
);
    import chop_pkg::*;

    leg_pair_t pr;
    logic      pulse;

    assign pr    = decode_sector(sector);
    assign pulse = (cnt > cmp_act) && pr.vld;

    // Route the same pulse to the source high side and the return low side.
    always_comb begin
        for (int l = 0; l < 3; l++) begin
            hi_req[l] = pulse && (pr.src == 2'(l));
            lo_req[l] = pulse && (pr.ret == 2'(l));
        end
    end
endmodule

// File: rtl/chop_deadband.sv
// One inverter leg: dead-band insertion and fault kill.
// A gate may rise only when its partner is low and has been low for at
// least `dead` clocks. The outputs are registered.
module chop_deadband #(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault,
    input  logic [DT_W-1:0] dead,
    input  logic            hi_req,
    input  logic            lo_req,
    output logic            hi_q,
    output logic            lo_q
);
    localparam logic [DT_W-1:0] SAT = '1;

    logic [DT_W-1:0] hi_off, lo_off;
    logic            hi_go, lo_go;

    // Turn-on permission for each side of the leg.
    assign hi_go = hi_req && !lo_req && !lo_q && (lo_off >= dead);
    assign lo_go = lo_req && !hi_req && !hi_q && (hi_off >= dead);

    // Registered gates, cleared by reset or fault.
    always_ff @(posedge clk) begin
        if (!rst_n || fault) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_go;
            lo_q <= lo_go;
        end
    end

    // Saturating counters of clocks each side has been off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_off <= '0;
            lo_off <= '0;
        end else begin
            hi_off <= hi_q ? '0 : ((hi_off == SAT) ? SAT : hi_off + 1'b1);
            lo_off <= lo_q ? '0 : ((lo_off == SAT) ? SAT : lo_off + 1'b1);
        end
    end

    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_q && lo_q));
    assert_gap_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> !$past(lo_q));
    assert_gap_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_q) |-> !$past(hi_q));
    assert_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault) |-> (!hi_q && !lo_q));
endmodule

// File: rtl/chop_pwm_top.sv
// Current-regulated hard-chopping PWM generator: carrier, regulator,
// steering and three dead-band legs. It assumes the current sample is
// valid while conv_req is high.
module chop_pwm_top #(
    parameter int PERIOD  = 500,
    parameter int SMP_W   = 10,
    parameter int K_SHIFT = 0,
    parameter int DT_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] cur_ref,
    input  logic [SMP_W-1:0] cur_meas,
    input  logic [2:0]       sector,
    input  logic [DT_W-1:0]  dead_cycles,
    input  logic             fault,
    output logic             conv_req,
    output logic [2:0]       gate_hi,
    output logic [2:0]       gate_lo
);
    localparam int CNT_W = $clog2(PERIOD + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp_act;
    logic             at_peak, at_start;
    logic [2:0]       hi_req, lo_req;

    chop_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .cnt(cnt),
        .at_peak(at_peak), .at_start(at_start)
    );

    chop_regulator #(.PERIOD(PERIOD), .CNT_W(CNT_W), .SMP_W(SMP_W),
                     .K_SHIFT(K_SHIFT)) u_reg (
        .clk(clk), .rst_n(rst_n), .at_peak(at_peak), .at_start(at_start),
        .cur_ref(cur_ref), .cur_meas(cur_meas), .cmp_act(cmp_act)
    );

    chop_steer #(.CNT_W(CNT_W)) u_steer (
        .cnt(cnt), .cmp_act(cmp_act), .sector(sector),
        .hi_req(hi_req), .lo_req(lo_req)
    );

    // One dead-band stage per leg.
    generate
        for (genvar l = 0; l < 3; l++) begin : g_leg
            chop_deadband #(.DT_W(DT_W)) u_db (
                .clk(clk), .rst_n(rst_n), .fault(fault), .dead(dead_cycles),
                .hi_req(hi_req[l]), .lo_req(lo_req[l]),
                .hi_q(gate_hi[l]), .lo_q(gate_lo[l])
            );
        end
    endgenerate

    assign conv_req = at_peak;

    assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gate_hi, gate_lo}) <= 2);
    assert_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sector > 3'd5) |=> (gate_hi == 3'b000 && gate_lo == 3'b000));
endmodule

// File: tb/chop_pwm_top_tb_top.sv
`timescale 1ns/1ps
module chop_pwm_top_tb_top;
    localparam int P  = 20;
    localparam int KS = 1;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    cur_ref = '0;
    logic [9:0]    cur_meas = '0;
    logic [2:0]    sector = 3'd0;
    logic [DW-1:0] dead_cycles = DW'(3);
    logic          fault = 1'b0;
    logic          conv_req;
    logic [2:0]    gate_hi, gate_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chop_pwm_top #(.PERIOD(P), .SMP_W(10), .K_SHIFT(KS), .DT_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_ref(cur_ref), .cur_meas(cur_meas),
        .sector(sector), .dead_cycles(dead_cycles), .fault(fault),
        .conv_req(conv_req), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // {sector, ref, meas, expected width}. Gain is 2, and each vector
    // applies two peak updates. Widths follow 2*(P-c)-1.
    localparam int VEC [0:7][0:3] = '{
        '{0, 100,  97, 11},
        '{1,  50,  49, 27},
        '{2, 200, 200, 31},
        '{3,  10,  12, 23},
        '{4, 300, 301, 11},
        '{5,   0,   2,  0},   // R3 upper clamp
        '{0, 1023,  0, 39},   // R3 lower clamp
        '{2,   5,   0, 39}
    };
    localparam int SRC [0:5] = '{0, 0, 1, 1, 2, 2};
    localparam int RET [0:5] = '{1, 2, 2, 0, 0, 1};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for a peak, then count gate highs over the next full carrier cycle.
    task automatic measure(input int src, input int ret,
                           output int whi, output int wlo, output int woth);
        whi = 0; wlo = 0; woth = 0;
        do @(negedge clk); while (conv_req !== 1'b1);
        repeat (P) @(negedge clk);
        for (int k = 0; k < 2 * P; k++) begin
            @(negedge clk);
            for (int l = 0; l < 3; l++) begin
                if (l == src) whi += int'(gate_hi[l]); else woth += int'(gate_hi[l]);
                if (l == ret) wlo += int'(gate_lo[l]); else woth += int'(gate_lo[l]);
            end
        end
    endtask

    // Dead-band monitor: each turn-on needs a long enough partner-off run (R7).
    int   run_hi [0:2];
    int   run_lo [0:2];
    logic [2:0] prev_hi, prev_lo;
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < 3; l++) begin run_hi[l] = 0; run_lo[l] = 0; end
            prev_hi = '0; prev_lo = '0;
        end else begin
            for (int l = 0; l < 3; l++) begin
                run_hi[l] = gate_hi[l] ? 0 : run_hi[l] + 1;
                run_lo[l] = gate_lo[l] ? 0 : run_lo[l] + 1;
                if (gate_hi[l] && !prev_hi[l])
                    check(run_lo[l] >= int'(dead_cycles), "R7 hi turn-on gap", run_lo[l], int'(dead_cycles));
                if (gate_lo[l] && !prev_lo[l])
                    check(run_hi[l] >= int'(dead_cycles), "R7 lo turn-on gap", run_hi[l], int'(dead_cycles));
                if (gate_hi[l] && gate_lo[l])
                    check(1'b0, "R7 both gates high", 1, 0);
            end
            prev_hi = gate_hi; prev_lo = gate_lo;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int whi, wlo, woth, gap;
        // R9: reset state
        cur_ref = 10'(VEC[0][1]); cur_meas = 10'(VEC[0][2]); sector = 3'(VEC[0][0]);
        repeat (4) @(negedge clk);
        check(conv_req == 1'b0, "R9 conv_req in reset", int'(conv_req), 0);
        check({gate_hi, gate_lo} == 6'd0, "R9 gates in reset", int'({gate_hi, gate_lo}), 0);
        rst_n = 1'b1;
        // R1: first peak exactly P clocks after release; R9: no pulse before it
        for (int k = 1; k < P; k++) begin
            @(negedge clk);
            check(conv_req == 1'b0, "R1 early conv_req", int'(conv_req), 0);
            check({gate_hi, gate_lo} == 6'd0, "R9 gates after reset", int'({gate_hi, gate_lo}), 0);
        end

        // Vector walk: R2, R3, R4, R5
        for (int v = 0; v < 8; v++) begin
            measure(SRC[VEC[v][0]], RET[VEC[v][0]], whi, wlo, woth);
            check(whi == VEC[v][3], "R4 high-side width", whi, VEC[v][3]);
            check(wlo == VEC[v][3], "R5 low-side width", wlo, VEC[v][3]);
            check(woth == 0, "R5 idle gates", woth, 0);
            if (v < 7) begin
                sector = 3'(VEC[v+1][0]); cur_ref = 10'(VEC[v+1][1]); cur_meas = 10'(VEC[v+1][2]);
            end
        end

        // R1: peak spacing
        do @(negedge clk); while (conv_req !== 1'b1);
        gap = 0;
        do begin @(negedge clk); gap++; end while (conv_req !== 1'b1);
        check(gap == 2 * P, "R1 peak spacing", gap, 2 * P);

        // R7: reverse both legs at full duty with a long dead band
        dead_cycles = DW'(6);
        for (int r = 0; r < 4; r++) begin
            do @(negedge clk); while (conv_req !== 1'b1);
            repeat (P) @(negedge clk);
            sector = (r % 2 == 0) ? 3'd3 : 3'd0;
        end
        measure(0, 1, whi, wlo, woth);
        check(whi == 2 * P - 1, "R7 width after reversal", whi, 2 * P - 1);

        // R6: invalid sector
        sector = 3'd7;
        measure(-1, -1, whi, wlo, woth);
        check(woth == 0, "R6 sector 7 gates", woth, 0);
        sector = 3'd6;
        measure(-1, -1, whi, wlo, woth);
        check(woth == 0, "R6 sector 6 gates", woth, 0);

        // R8: fault kill and release
        sector = 3'd1;
        repeat (3 * P) @(negedge clk);
        fault = 1'b1;
        woth = 0;
        for (int k = 0; k < 2 * P; k++) begin
            @(negedge clk);
            woth += $countones({gate_hi, gate_lo});
        end
        check(woth == 0, "R8 gates under fault", woth, 0);
        fault = 1'b0;
        measure(0, 2, whi, wlo, woth);
        check(whi == 2 * P - 1, "R8 resume after fault", whi, 2 * P - 1);

        // R9: reset mid-run restores the compare to PERIOD (no pulse)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check({gate_hi, gate_lo} == 6'd0, "R9 gates in mid-run reset", int'({gate_hi, gate_lo}), 0);
        cur_ref = 10'd0; cur_meas = 10'd0;
        rst_n = 1'b1;
        measure(0, 2, whi, wlo, woth);
        check(whi == 0 && wlo == 0, "R9 compare after reset", whi + wlo, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule